// File: doc/BRIEF.md
# ISA Master Memory Cycle Generator

This block runs a single 16-bit memory read or memory write on an ISA bus that the chip already owns. A one-clock start pulse latches a direction, a 24-bit address and, for writes, 16 bits of data. The block then walks through four phases, each counted in clocks of the 20 MHz bus timing clock: address setup, command active, command recovery, and finally a one-clock completion pulse. The address is presented on the low 20-bit system address bus and on the high 7-bit latched address bus.

The length of the active phase is programmable in clocks, with separate values for reads and writes. A width of zero is raised to one clock, so the command is always asserted. The bus ready input can stretch the active phase further. After the command ends, the bus stays idle for a recovery time. That time is 2 clocks for plain ISA timing and 4 clocks for the slower extended-bus timing. Memory is always treated as 16 bits wide, so the byte-high-enable strobe is asserted for every cycle.

Bus arbitration and the splitting of transfers into 8-bit halves are handled elsewhere. The block only sequences one cycle at a time.

Top module: `isa_mem_cycle`

## Requirements
- R1: After reset, `memr_n_o` and `memw_n_o` are high (inactive), `sbhe_n_o` is high, and `data_oe_o` and `done_o` are low.
- R2: In the first clock after a start is sampled in idle, the address is already on the bus while both commands are still inactive. `sa_o` equals address bits 19:0, `la_o` equals address bits 23:17, and `sbhe_n_o` is low. The selected command goes low in the next clock. The address stays stable while the command is low.
- R3: With the bus ready input held high, the command stays low for exactly the programmed number of clocks. Reads use `rd_width_i` and writes use `wr_width_i`, and a value of 0 gives 1 clock.
- R4: The command can only end at a clock edge where the width count has run out and `iochrdy_i` is high. A low ready input keeps the command active.
- R5: For a read, `rdata_o` holds the value of `bus_din_i` sampled at the clock edge that ends the command (the last edge with `memr_n_o` low).
- R6: For a write, `data_oe_o` is high, with `data_out_o` equal to the write data, from the setup clock through the one clock after `memw_n_o` rises. It is low afterwards.
- R7: After the command rises, both commands stay inactive for a recovery time. The recovery is 2 clocks when `short_recov_i` is 1 and 4 clocks when it is 0. `done_o` rises exactly that many clocks after the command rises.
- R8: `done_o` is a single-clock pulse. A start that arrives while a cycle is in progress is ignored: the address and the command timing are unchanged, and no extra cycle follows.
- R9: `memr_n_o` and `memw_n_o` are never low at the same time. A read never drives `data_oe_o`, and a read never lowers `memw_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus timing clock (20 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock request to begin a cycle; honoured only when idle |
| we_i | input | 1 | 1 = memory write, 0 = memory read |
| addr_i | input | 24 | Byte address of the transfer |
| wdata_i | input | 16 | Data for a write |
| rd_width_i | input | WIDTH_W | Read command width in clocks (0 acts as 1) |
| wr_width_i | input | WIDTH_W | Write command width in clocks (0 acts as 1) |
| short_recov_i | input | 1 | 1 = 2-clock recovery, 0 = 4-clock recovery |
| iochrdy_i | input | 1 | Bus ready; low stretches the command |
| bus_din_i | input | 16 | Data bus value seen during reads |
| sa_o | output | 20 | System address bits 19:0 |
| la_o | output | 7 | Latched address bits 23:17 |
| sbhe_n_o | output | 1 | Byte-high enable, active low, asserted for the whole cycle |
| memr_n_o | output | 1 | Memory read command, active low |
| memw_n_o | output | 1 | Memory write command, active low |
| data_out_o | output | 16 | Write data driven to the bus |
| data_oe_o | output | 1 | Output enable for `data_out_o` |
| rdata_o | output | 16 | Data captured by the last read |
| done_o | output | 1 | One-clock pulse when recovery has finished |

## Verification
Counting falling-edge samples from the start pulse as sample 0:
- Sample 1 shows the address with both commands high.
- Sample 2 is the first with the command low.
- The last low sample is 1 + max(width, stall + 1). Without a stall this reduces to 1 + width.
- The command rises at the next sample.
- `done_o` appears exactly 2 or 4 samples after the rise.

Each task records the sample index at which every event occurs and compares it against these expected positions, rather than waiting for the events to happen. During a read, the bench changes `bus_din_i` at every sample. Only the value present at the final active edge can then match `rdata_o`, which pins the capture to that edge.

// File: rtl/isamc_pkg.sv
package isamc_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 16;
    localparam int SA_W    = 20;
    localparam int LA_LSB  = 17;
    localparam int LA_W    = ADDR_W - LA_LSB;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACT,
        ST_REC
    } isamc_state_e;
endpackage

// File: rtl/isamc_width_sel.sv
// Picks the command width for the current direction; zero is lifted to one clock.
module isamc_width_sel #(
    parameter int WIDTH_W = 4
) (
    input  logic               we_i,
    input  logic [WIDTH_W-1:0] rd_width_i,
    input  logic [WIDTH_W-1:0] wr_width_i,
    output logic [WIDTH_W-1:0] eff_width_o
);
    logic [WIDTH_W-1:0] raw;

    always_comb begin
        raw = we_i ? wr_width_i : rd_width_i;
        eff_width_o = (raw == '0) ? WIDTH_W'(1) : raw;
    end
endmodule

// File: rtl/isamc_recov_sel.sv
// Recovery length in clocks, chosen between the short and the long bus timing.
module isamc_recov_sel #(
    parameter int CNT_W      = 3,
    parameter int SHORT_CLKS = 2,
    parameter int LONG_CLKS  = 4
) (
    input  logic             short_i,
    output logic [CNT_W-1:0] recov_o
);
    always_comb begin
        recov_o = short_i ? CNT_W'(SHORT_CLKS) : CNT_W'(LONG_CLKS);
    end
endmodule

// File: rtl/isa_mem_cycle.sv
module isa_mem_cycle
    import isamc_pkg::*;
#(
    parameter int WIDTH_W    = 4,
    parameter int ISA_RECOV  = 2,
    parameter int EISA_RECOV = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [WIDTH_W-1:0]  rd_width_i,
    input  logic [WIDTH_W-1:0]  wr_width_i,
    input  logic                short_recov_i,
    input  logic                iochrdy_i,
    input  logic [DATA_W-1:0]   bus_din_i,
    output logic [SA_W-1:0]     sa_o,
    output logic [LA_W-1:0]     la_o,
    output logic                sbhe_n_o,
    output logic                memr_n_o,
    output logic                memw_n_o,
    output logic [DATA_W-1:0]   data_out_o,
    output logic                data_oe_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                done_o
);
    localparam int REC_MAX = (ISA_RECOV > EISA_RECOV) ? ISA_RECOV : EISA_RECOV;
    localparam int REC_W   = $clog2(REC_MAX + 1);
    localparam int CNT_W   = (WIDTH_W > REC_W) ? WIDTH_W : REC_W;

    typedef struct packed {
        isamc_state_e        state;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic [CNT_W-1:0]    cnt;
        logic                memr_n;
        logic                memw_n;
        logic                oe;
        logic                done;
    } regs_t;

    regs_t r_d, r_q;

    logic [WIDTH_W-1:0] eff_width;
    logic [CNT_W-1:0]   recov_clks;

    isamc_width_sel #(.WIDTH_W(WIDTH_W)) u_width (
        .we_i        (r_q.we),
        .rd_width_i  (rd_width_i),
        .wr_width_i  (wr_width_i),
        .eff_width_o (eff_width)
    );

    isamc_recov_sel #(
        .CNT_W      (CNT_W),
        .SHORT_CLKS (ISA_RECOV),
        .LONG_CLKS  (EISA_RECOV)
    ) u_recov (
        .short_i (short_recov_i),
        .recov_o (recov_clks)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_SETUP;
                    r_d.we    = we_i;
                    r_d.addr  = addr_i;
                    r_d.wdata = wdata_i;
                    r_d.oe    = we_i;
                end
            end
            ST_SETUP: begin
                // address has been out for one clock: assert the command
                r_d.state  = ST_ACT;
                r_d.cnt    = CNT_W'(eff_width) - CNT_W'(1);
                r_d.memr_n = r_q.we;
                r_d.memw_n = !r_q.we;
            end
            ST_ACT: begin
                if (r_q.cnt == '0 && iochrdy_i) begin
                    r_d.state  = ST_REC;
                    r_d.memr_n = 1'b1;
                    r_d.memw_n = 1'b1;
                    r_d.cnt    = recov_clks - CNT_W'(1);
                    if (!r_q.we) begin
                        r_d.rdata = bus_din_i;
                    end
                end else if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_REC: begin
                // write data stays on for the first recovery clock only
                r_d.oe = 1'b0;
                if (r_q.cnt == '0) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
            r_q.memr_n <= 1'b1;
            r_q.memw_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sa_o       = r_q.addr[SA_W-1:0];
    assign la_o       = r_q.addr[ADDR_W-1:LA_LSB];
    assign sbhe_n_o   = (r_q.state == ST_IDLE);
    assign memr_n_o   = r_q.memr_n;
    assign memw_n_o   = r_q.memw_n;
    assign data_out_o = r_q.wdata;
    assign data_oe_o  = r_q.oe;
    assign rdata_o    = r_q.rdata;
    assign done_o     = r_q.done;
endmodule

// File: rtl/isamc_checker.sv
module isamc_checker
    import isamc_pkg::*;
#(
    parameter int WIDTH_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               we_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic [WIDTH_W-1:0] rd_width_i,
    input logic [WIDTH_W-1:0] wr_width_i,
    input logic               short_recov_i,
    input logic               iochrdy_i,
    input logic [DATA_W-1:0]  bus_din_i,
    input logic [SA_W-1:0]    sa_o,
    input logic [LA_W-1:0]    la_o,
    input logic               sbhe_n_o,
    input logic               memr_n_o,
    input logic               memw_n_o,
    input logic [DATA_W-1:0]  data_out_o,
    input logic               data_oe_o,
    input logic [DATA_W-1:0]  rdata_o,
    input logic               done_o
);
    logic cmd_act;
    assign cmd_act = !memr_n_o || !memw_n_o;

    AST_ADDR_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_act) |-> $past(!sbhe_n_o)) else $error("address setup");           // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act && $past(cmd_act)) |-> ($stable(sa_o) && $stable(la_o))) else $error("addr moved"); // R2
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act && !iochrdy_i) |=> cmd_act) else $error("ready ignored");            // R4
    AST_WDATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(memw_n_o) |-> $past(data_oe_o)) else $error("write data late");        // R6
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(memw_n_o) |-> data_oe_o) else $error("write data hold");               // R6
    AST_RECOV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(memr_n_o) || $rose(memw_n_o)) |=> (memr_n_o && memw_n_o)) else $error("recovery"); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done width");                               // R8
    AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!memr_n_o && !memw_n_o)) else $error("both commands");                     // R9
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !memr_n_o |-> !data_oe_o) else $error("drive during read");                  // R9
endmodule

bind isa_mem_cycle isamc_checker #(.WIDTH_W(WIDTH_W)) u_chk (.*);

// File: tb/isa_mem_cycle_bench.sv
module isa_mem_cycle_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        we_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [3:0]  rd_width_i = 4'd5;
    logic [3:0]  wr_width_i = 4'd5;
    logic        short_recov_i = 1'b1;
    logic        iochrdy_i = 1'b1;
    logic [15:0] bus_din_i = '0;
    logic [19:0] sa_o;
    logic [6:0]  la_o;
    logic        sbhe_n_o, memr_n_o, memw_n_o, data_oe_o, done_o;
    logic [15:0] data_out_o, rdata_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    isa_mem_cycle u_isa_mem_cycle (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(memr_n_o == 1'b1 && memw_n_o == 1'b1, "R1 commands idle", {memr_n_o, memw_n_o}, 3);
        chk(sbhe_n_o == 1'b1, "R1 sbhe idle", sbhe_n_o, 1);
        chk(data_oe_o == 1'b0 && done_o == 1'b0, "R1 oe/done low", {data_oe_o, done_o}, 0);
    endtask

    // One full cycle. stall = number of ready-low edges after the first active sample.
    task automatic do_cycle(input bit we, input logic [23:0] addr, input logic [15:0] wd,
                            input int width, input int stall, input bit short_r);
        int eff, act, rec, first_low, last_low, done_idx, done_cnt, oe_last, wrong_cmd;
        logic [15:0] rpat;
        bit cmdl;
        eff = (width == 0) ? 1 : width;
        act = (stall == 0) ? eff : ((eff > stall + 1) ? eff : stall + 1);
        rec = short_r ? 2 : 4;
        rpat = addr[15:0] ^ 16'h5a5a;
        first_low = -1; last_low = -1; done_idx = -1; done_cnt = 0; oe_last = 0; wrong_cmd = 0;

        @(negedge clk);
        we_i = we; addr_i = addr; wdata_i = wd; short_recov_i = short_r;
        if (we) wr_width_i = 4'(width); else rd_width_i = 4'(width);
        iochrdy_i = (stall == 0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // sample 1: setup clock
        chk(memr_n_o && memw_n_o, "R2 no command in setup", {memr_n_o, memw_n_o}, 3);
        chk(sa_o == addr[19:0] && la_o == addr[23:17] && !sbhe_n_o, "R2 address in setup",
            int'(sa_o), int'(addr[19:0]));
        if (data_oe_o) oe_last = 1;
        bus_din_i = rpat + 16'd1;
        for (int i = 2; i < 80; i++) begin
            @(negedge clk);
            cmdl = we ? !memw_n_o : !memr_n_o;
            if (we ? !memr_n_o : !memw_n_o) wrong_cmd++;
            if (cmdl && first_low < 0) first_low = i;
            if (cmdl) last_low = i;
            if (data_oe_o) oe_last = i;
            if (done_o) begin
                done_cnt++;
                if (done_idx < 0) done_idx = i;
            end
            bus_din_i = rpat + 16'(i);
            if (stall != 0 && i == 2 + stall) iochrdy_i = 1'b1;
            if (done_idx > 0 && i >= done_idx + 2) break;
        end
        chk(first_low == 2, "R2 command one clock after address", first_low, 2);
        chk(last_low - first_low + 1 == act, stall ? "R4 stretched width" : "R3 command width",
            last_low - first_low + 1, act);
        chk(done_idx == last_low + 1 + rec, "R7 recovery then done", done_idx, last_low + 1 + rec);
        chk(done_cnt == 1, "R8 done single clock", done_cnt, 1);
        chk(wrong_cmd == 0, "R9 other command idle", wrong_cmd, 0);
        chk(sa_o == addr[19:0], "R2 address held", int'(sa_o), int'(addr[19:0]));
        if (we) begin
            chk(oe_last == last_low + 1, "R6 write data hold", oe_last, last_low + 1);
            chk(data_out_o == wd, "R6 write data value", int'(data_out_o), int'(wd));
        end else begin
            chk(oe_last == 0, "R9 read never drives", oe_last, 0);
            chk(rdata_o == rpat + 16'(last_low), "R5 read capture at end", int'(rdata_o),
                int'(rpat + 16'(last_low)));
        end
        iochrdy_i = 1'b1;
    endtask

    task automatic t_ignore_start();
        int extra;
        extra = 0;
        @(negedge clk);
        we_i = 1'b1; addr_i = 24'h12_3456; wdata_i = 16'hbeef; wr_width_i = 4'd3;
        short_recov_i = 1'b1; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_i = 1'b0; addr_i = 24'hab_cdef; start_i = 1'b1;   // in mid-cycle
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!memr_n_o) extra++;
        end
        chk(sa_o == 20'h23456, "R8 late start ignored addr", int'(sa_o), 'h23456);
        chk(extra == 0, "R8 no extra read cycle", extra, 0);
        chk(sbhe_n_o == 1'b1, "R8 back to idle", sbhe_n_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        do_cycle(1'b0, 24'h0a_1234, 16'h0, 5, 0, 1'b1);      // default read
        do_cycle(1'b0, 24'hfe_0002, 16'h0, 0, 0, 1'b0);      // zero width, long recovery
        do_cycle(1'b0, 24'h31_8000, 16'h0, 2, 5, 1'b1);      // ready stall
        do_cycle(1'b1, 24'h7f_fffe, 16'h1357, 5, 0, 1'b1);   // default write
        do_cycle(1'b1, 24'h00_0010, 16'hc0de, 3, 6, 1'b0);   // stalled write, long recovery
        do_cycle(1'b1, 24'h80_0020, 16'ha5a5, 0, 0, 1'b1);   // zero width write
        do_cycle(1'b0, 24'h40_0044, 16'h0, 15, 0, 1'b0);     // widest read
        t_ignore_start();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule